// File: doc/BRIEF.md
# Three-Edge Chip-Select Converter Sequencer

This block is the digital control core of a 16-bit successive-approximation converter with a byte-wide parallel output. One active-low chip-select line steps the converter through three phases. A read/convert select input is sampled at each falling edge, and its meaning depends on the phase:

- At the first edge it starts acquisition.
- At the second edge it chooses the power-down mode used after the conversion.
- At the third edge it requests the result.

An internal clock counter runs the approximation loop. The loop presents a trial word to an external comparator and takes back a one-bit keep/drop decision for each bit.

When the conversion finishes, an active-low end-of-conversion flag goes low. The block then applies the latched power mode:

- Standby keeps the reference and its buffer powered.
- Shutdown turns both off.

A later wake-up from shutdown holds the reference-ready indication low until a settle counter expires. The result leaves the block one byte at a time, chosen by a high-byte enable. The bus is released whenever chip select is high or a conversion is under way.

Top module: `cs3_adc_sequencer`

## Requirements
- R1: After reset, eoc_n is 1, bus_oe is 0, ref_pwr_en is 0, ref_ready is 0 and proto_err is 0.
- R2: In the idle phase, a chip-select falling edge with rd_conv low powers the reference (ref_pwr_en=1) and enters acquisition. The same edge with rd_conv high is ignored, and the reference stays off.
- R3: The falling edge that ends acquisition starts conversion. The first trial word is 0x8000. Bits are decided MSB first, with cmp_keep=1 keeping the trial bit. The result is straight binary.
- R4: eoc_n falls no sooner than DATA_W*CLKS_PER_BIT and no later than CONV_MAX clock cycles after the chip-select edge that starts conversion.
- R5: rd_conv at the conversion-start edge picks the mode: 0 is standby and 1 is shutdown. When eoc_n falls, ref_pwr_en stays 1 in standby and drops to 0 in shutdown.
- R6: After eoc_n falls, a falling edge with rd_conv high sets bus_oe=1. Raising chip select then clears bus_oe and returns eoc_n to 1.
- R7: While the bus is driven, hi_byte=1 puts result bits 15..8 on bus_q and hi_byte=0 puts bits 7..0.
- R8: bus_oe stays 0 throughout acquisition and conversion.
- R9: After power-up from shutdown, ref_ready stays 0 for SETTLE_CYC cycles and then rises. After standby, ref_ready is already 1 when acquisition starts.
- R10: A chip-select falling edge during conversion does not disturb the conversion or its result, and it sets proto_err, which stays set until reset.
- R11: After eoc_n falls, a falling edge with rd_conv low skips the read. It returns eoc_n to 1, keeps the bus released and starts a new acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| rd_conv | input | 1 | Read/convert select, sampled at chip-select falls |
| hi_byte | input | 1 | Byte select for the output bus |
| cmp_keep | input | 1 | Comparator decision for the current trial word |
| trial_word | output | DATA_W | Trial code presented to the comparator |
| eoc_n | output | 1 | Active-low end-of-conversion flag |
| bus_q | output | DATA_W/2 | Output byte, zero while released |
| bus_oe | output | 1 | Tri-state enable for the output pads |
| ref_pwr_en | output | 1 | Power enable for the reference and its buffer |
| ref_ready | output | 1 | Reference settled and usable |
| proto_err | output | 1 | Sticky flag for a chip-select edge during conversion |

## Verification
The approximation loop finishing and a chip-select falling edge can land in the same cycle while the block is still converting. In that case the completion is taken, and the edge only raises the error flag. The bench provokes a stray edge well inside a conversion, with rd_conv high so that it looks like a read request. It then judges that eoc_n still falls inside the R4 window, that the read-back byte values are the exact target code, and that proto_err latches and stays set through later conversions.

// File: rtl/csq_pkg.sv
package csq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACQ  = 3'd1,
      ST_CONV = 3'd2,
      ST_DONE = 3'd3,
      ST_READ = 3'd4
   } seq_state_e;
endpackage

// File: rtl/csq_sync.sv
module csq_sync #(
   parameter int          NBITS    = 3,
   parameter logic [31:0] RST_VAL  = 32'h1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] din,
   output logic [NBITS-1:0] dout
);
   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         logic ff1, ff2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff1 <= RST_VAL[i];
               ff2 <= RST_VAL[i];
            end else begin
               ff1 <= din[i];
               ff2 <= ff1;
            end
         end
         assign dout[i] = ff2;
      end
   endgenerate
endmodule

// File: rtl/csq_sar.sv
module csq_sar #(
   parameter int DATA_W       = 16,
   parameter int CLKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cmp_keep,
   output logic [DATA_W-1:0] trial,
   output logic              done
);
   localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
   localparam int SW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [TW-1:0] TICK_LAST = TW'(CLKS_PER_BIT - 1);
   localparam logic [SW-1:0] STEP_MSB  = SW'(DATA_W - 1);

   logic [DATA_W-1:0] acc;
   logic [SW-1:0]     step;
   logic [TW-1:0]     tick;
   logic              busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         step <= '0;
         tick <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            acc              <= '0;
            acc[DATA_W-1]    <= 1'b1;
            step             <= STEP_MSB;
            tick             <= '0;
            busy             <= 1'b1;
         end else if (busy) begin
            if (tick == TICK_LAST) begin
               tick <= '0;
               if (!cmp_keep) acc[step] <= 1'b0;
               if (step == '0) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  acc[step - 1'b1] <= 1'b1;
                  step             <= step - 1'b1;
               end
            end else begin
               tick <= tick + 1'b1;
            end
         end
      end
   end

   assign trial = acc;
endmodule

// File: rtl/csq_ref_settle.sv
module csq_ref_settle #(
   parameter int SETTLE_CYC = 720000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   output logic ready
);
   localparam int CW = $clog2(SETTLE_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= LOAD;
      else if (!pwr_on)        remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign ready = pwr_on && (remain == '0);
endmodule

// File: rtl/cs3_adc_sequencer.sv
module cs3_adc_sequencer
   import csq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CLKS_PER_BIT = 16,
   parameter int CONV_MAX     = 282,
   parameter int SETTLE_CYC   = 720000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rd_conv,
   input  logic                hi_byte,
   input  logic                cmp_keep,
   output logic [DATA_W-1:0]   trial_word,
   output logic                eoc_n,
   output logic [DATA_W/2-1:0] bus_q,
   output logic                bus_oe,
   output logic                ref_pwr_en,
   output logic                ref_ready,
   output logic                proto_err
);
   localparam int HALF     = DATA_W / 2;
   localparam int SYNC_LAT = 4;

   generate
      if (DATA_W % 2 != 0) begin : g_chk_even
         $error("DATA_W must be even");
      end
      if (CLKS_PER_BIT < 2) begin : g_chk_cpb
         $error("CLKS_PER_BIT must be at least 2");
      end
      if (DATA_W * CLKS_PER_BIT + SYNC_LAT > CONV_MAX) begin : g_chk_bound
         $error("conversion cannot finish within CONV_MAX");
      end
      if (SETTLE_CYC < 1) begin : g_chk_settle
         $error("SETTLE_CYC must be positive");
      end
   endgenerate

   logic [2:0] sync_q;
   logic       cs_s, rc_s, hb_s, cs_prev;
   logic       cs_fall, cs_rise;

   csq_sync #(.NBITS(3), .RST_VAL(32'h1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({hi_byte, rd_conv, cs_n}),
      .dout (sync_q)
   );

   assign cs_s = sync_q[0];
   assign rc_s = sync_q[1];
   assign hb_s = sync_q[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev <= 1'b1;
      else        cs_prev <= cs_s;
   end

   assign cs_fall = cs_prev & ~cs_s;
   assign cs_rise = ~cs_prev & cs_s;

   seq_state_e state_q;
   logic       shdn_q, ref_on_q, err_q;
   logic       sar_start, sar_done;
   logic [DATA_W-1:0] sar_word;

   assign sar_start = (state_q == ST_ACQ) && cs_fall;

   csq_sar #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_sar (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sar_start),
      .cmp_keep(cmp_keep),
      .trial   (sar_word),
      .done    (sar_done)
   );

   csq_ref_settle #(.SETTLE_CYC(SETTLE_CYC)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .pwr_on(ref_on_q),
      .ready (ref_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shdn_q   <= 1'b1;
         ref_on_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cs_fall && !rc_s) begin
               state_q  <= ST_ACQ;
               ref_on_q <= 1'b1;
            end
            ST_ACQ: if (cs_fall) begin
               state_q <= ST_CONV;
               shdn_q  <= rc_s;
            end
            ST_CONV: begin
               if (cs_fall) err_q <= 1'b1;
               if (sar_done) begin
                  state_q <= ST_DONE;
                  if (shdn_q) ref_on_q <= 1'b0;
               end
            end
            ST_DONE: if (cs_fall) begin
               if (rc_s) begin
                  state_q <= ST_READ;
               end else begin
                  state_q  <= ST_ACQ;
                  ref_on_q <= 1'b1;
               end
            end
            ST_READ: if (cs_rise) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign trial_word = sar_word;
   assign eoc_n      = !((state_q == ST_DONE) || (state_q == ST_READ));
   assign bus_oe     = (state_q == ST_READ);
   assign bus_q      = bus_oe ? (hb_s ? sar_word[DATA_W-1:HALF] : sar_word[HALF-1:0])
                              : '0;
   assign ref_pwr_en = ref_on_q;
   assign proto_err  = err_q;
endmodule

// File: rtl/csq_seq_chk.sv
module csq_seq_chk
   import csq_pkg::*;
#(
   parameter int CONV_MAX = 282
) (
   input logic       clk,
   input logic       rst_n,
   input logic       eoc_n,
   input logic       bus_oe,
   input logic       ref_pwr_en,
   input logic       ref_ready,
   input logic       proto_err,
   input seq_state_e state,
   input logic       shdn_q
);
   localparam int CW = $clog2(CONV_MAX + 2);
   logic [CW-1:0] conv_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  conv_cnt <= '0;
      else if (state != ST_CONV)   conv_cnt <= '0;
      else if (conv_cnt != '1)     conv_cnt <= conv_cnt + 1'b1;
   end

   AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      conv_cnt <= CW'(CONV_MAX)); // R4
   AST_ACQ_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACQ) |-> ref_pwr_en); // R2
   AST_BUS_NEEDS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> !eoc_n); // R6
   AST_BUS_QUIET_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ACQ) || (state == ST_CONV)) |-> !bus_oe); // R8
   AST_SHDN_DROPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(eoc_n) && shdn_q) |-> !ref_pwr_en); // R5
   AST_STBY_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(eoc_n) && !shdn_q) |-> ref_pwr_en); // R5
   AST_READY_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ready |-> ref_pwr_en); // R9
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err); // R10
endmodule

bind cs3_adc_sequencer csq_seq_chk #(.CONV_MAX(CONV_MAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eoc_n     (eoc_n),
   .bus_oe    (bus_oe),
   .ref_pwr_en(ref_pwr_en),
   .ref_ready (ref_ready),
   .proto_err (proto_err),
   .state     (state_q),
   .shdn_q    (shdn_q)
);

// File: tb/test_cs3_adc_sequencer.sv
module test_cs3_adc_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int CPB        = 4;
   localparam int CMAX       = 80;
   localparam int SETTLE     = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rd_conv = 1'b0, hi_byte = 1'b0;
   logic [W-1:0]   target = '0;
   logic [W-1:0]   trial_word;
   logic           cmp_keep;
   logic           eoc_n, bus_oe, ref_pwr_en, ref_ready, proto_err;
   logic [W/2-1:0] bus_q;
   int compared = 0;
   int mismatched = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign cmp_keep = (trial_word <= target);

   cs3_adc_sequencer #(.DATA_W(W), .CLKS_PER_BIT(CPB), .CONV_MAX(CMAX),
                       .SETTLE_CYC(SETTLE)) i_cs3_adc_sequencer (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv), .hi_byte(hi_byte),
      .cmp_keep(cmp_keep), .trial_word(trial_word), .eoc_n(eoc_n), .bus_q(bus_q),
      .bus_oe(bus_oe), .ref_pwr_en(ref_pwr_en), .ref_ready(ref_ready),
      .proto_err(proto_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cs_edge(input logic rc);
      @(negedge clk) rd_conv = rc;
      repeat (2) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 eoc_n", eoc_n, 1);
      chk("R1 bus_oe", bus_oe, 0);
      chk("R1 ref_pwr_en", ref_pwr_en, 0);
      chk("R1 ref_ready", ref_ready, 0);
      chk("R1 proto_err", proto_err, 0);
   endtask

   task automatic t_ignore();
      cs_edge(1'b1);
      chk("R2 ignored edge ref", ref_pwr_en, 0);
      chk("R2 ignored edge eoc", eoc_n, 1);
      chk("R2 ignored edge bus", bus_oe, 0);
   endtask

   task automatic t_acquire(input bit from_shdn);
      cs_edge(1'b0);
      chk("R2 acquire powers ref", ref_pwr_en, 1);
      chk("R8 bus off in acquire", bus_oe, 0);
      chk("R9 ready at acquire", ref_ready, from_shdn ? 0 : 1);
      if (from_shdn) begin
         repeat (SETTLE + 5) @(negedge clk);
         chk("R9 ready after settle", ref_ready, 1);
      end
   endtask

   task automatic t_convert(input logic mode, input logic [W-1:0] code,
                            input bit spur, input logic err_exp);
      int n;
      target = code;
      @(negedge clk) rd_conv = mode;
      repeat (2) @(negedge clk);
      cs_n = 1'b0;
      n = 0;
      while (eoc_n && n < 1000) begin
         @(negedge clk);
         n++;
         if (n == 2) cs_n = 1'b1;
         if (n == 3) chk("R3 first trial word", trial_word, 32'h8000);
         if (n == 5) chk("R8 bus off in conversion", bus_oe, 0);
         if (spur && n == 12) begin rd_conv = 1'b1; cs_n = 1'b0; end
         if (spur && n == 15) cs_n = 1'b1;
      end
      chk("R4 eoc not early", (n >= W*CPB), 1);
      chk("R4 eoc within bound", (n <= CMAX), 1);
      chk("R5 ref after eoc", ref_pwr_en, mode ? 0 : 1);
      chk("R10 protocol flag", proto_err, err_exp);
      rd_conv = 1'b0;
   endtask

   task automatic t_read(input logic [W-1:0] code);
      @(negedge clk) begin rd_conv = 1'b1; hi_byte = 1'b1; end
      repeat (2) @(negedge clk);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R6 bus driven", bus_oe, 1);
      chk("R7 high byte", bus_q, code[15:8]);
      chk("R3 result eoc low", eoc_n, 0);
      hi_byte = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7 low byte", bus_q, code[7:0]);
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R6 bus released", bus_oe, 0);
      chk("R6 eoc high", eoc_n, 1);
      rd_conv = 1'b0;
   endtask

   task automatic t_skip_read();
      cs_edge(1'b0);
      chk("R11 eoc high on skip", eoc_n, 1);
      chk("R11 bus off on skip", bus_oe, 0);
      chk("R11 ref on in acquire", ref_pwr_en, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_ignore();
      t_acquire(1);
      t_convert(1'b0, 16'hA5C3, 0, 1'b0);
      t_read(16'hA5C3);
      t_acquire(0);
      t_convert(1'b1, 16'h0000, 1, 1'b1);
      t_read(16'h0000);
      t_acquire(1);
      t_convert(1'b0, 16'hFFFF, 0, 1'b1);
      t_skip_read();
      t_convert(1'b0, 16'h1234, 0, 1'b1);
      t_read(16'h1234);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule